// File: doc/BRIEF.md
# Four-Channel Converter Register Slave on a Two-Wire Bus

This block is the digital front end of a four-channel, 10-bit converter. It listens to a two-wire serial bus (a clock line and an open-drain data line). It keeps one 10-bit code per channel and a 2-bit power-down mode per channel. The bus lines arrive unsynchronised. Both are resampled on the system clock. START and STOP are recognised as data-line edges while the clock line is high. The block pulls the data line low only through an output enable.

A write transaction consists of three bytes:

1. The 7-bit device address with the direction bit.
2. A byte holding a 4-bit command and the upper code bits.
3. A byte holding the lower code bits, or a channel-select mask and mode for the power-down command.

A read transaction returns the selected channel in two bytes. After an address mismatch, the block ignores bus clock activity until it sees a new START.

Top module: `qdac_i2c_slave`

## Requirements
- R1: After reset, every code output is 0, every power-down mode is 00, and `sda_oe` is 0.
- R2: Address acknowledge.
  - When the address byte's bits 7..1 equal `DEV_ADDR`, the block pulls SDA low during the ninth clock pulse.
  - `sda_oe` is high only during an acknowledge slot or while sending read data.
- R3: The general call address (bits 7..1 = 0000000) and any 10-bit header (bits 7..3 = 11110) get no acknowledge and change no register.
- R4: Behaviour after an address mismatch.
  - Clock pulses and data that follow the mismatch are ignored, so no acknowledge is given and nothing changes.
  - The block responds again from the next START, including a repeated START.
- R5: Write-byte layout.
  - Write byte 1 carries the command in bits 7..4 and code bits 9..6 in bits 3..0.
  - Write byte 2 carries code bits 5..0 in bits 7..2. Its bits 1..0 are ignored.
  - Commands 0x0 to 0x3 load channel 0 to 3. Channel n appears at `dac_code[10n+9:10n]`.
- R6: Command 0x8 loads the same code into all four channels.
- R7: Command 0xF is the power-down command.
  - Byte 2 bits 4, 5, 6 and 7 select channels 0, 1, 2 and 3.
  - Bits 1..0 give the mode, which is written to `pd_mode[2n+1:2n]` of every selected channel.
  - The code registers are unchanged.
- R8: Any other command is acknowledged but changes no register.
- R9: A STOP or START before the acknowledge of the second data byte has completed leaves every register unchanged.
- R10: Read data.
  - With direction bit 1, the block sends `{mode[2], channel[2], code[9:6]}` and then `{code[5:0], 00}`. The channel is the one named by the last single-channel load (0 after reset).
  - Each further byte is sent only when the master acknowledges, and the two bytes alternate.
- R11: If the master does not acknowledge a read byte, SDA is released and the block stays silent until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, unsynchronised |
| sda_in | input | 1 | Bus data line level, unsynchronised |
| sda_oe | output | 1 | 1 pulls the data line low |
| dac_code | output | 40 | Four 10-bit channel codes, channel 0 in the low bits |
| pd_mode | output | 8 | Four 2-bit power-down modes, channel 0 in the low bits |

## Verification
A wrong bit counter or state in the byte engine shows up within one byte time as follows:
- an acknowledge that lands on the wrong clock pulse, or one that is missing;
- a read byte that is shifted;
- a code register loaded with misaligned bits.

A stale first-byte holding register or a lost abort appears on the code or mode outputs right after the faulty transaction ends. A gate that fails to close after a mismatch shows as an acknowledge to a later byte that no START introduced.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  parameter int NCH = 4;
  parameter int CW  = 10;
  parameter int PDW = 2;
  localparam int CHW = $clog2(NCH);

  localparam logic [3:0] CMD_ALL = 4'h8;
  localparam logic [3:0] CMD_EXT = 4'hF;

  typedef enum logic [2:0] {
    B_IDLE, B_ADDR, B_AACK, B_RX, B_DACK, B_TX, B_RACK
  } bus_st_t;

  function automatic logic addr_ok(input logic [7:0] b, input logic [6:0] dev);
    return (b[7:1] == dev) && (b[7:1] != 7'd0) && (b[7:3] != 5'b11110);
  endfunction

  function automatic logic [CW-1:0] code_of(input logic [7:0] b0, input logic [7:0] b1);
    return {b0[3:0], b1[7:2]};
  endfunction

  function automatic logic [7:0] rd_hi(input logic [PDW-1:0] pd, input logic [CHW-1:0] ch,
                                       input logic [CW-1:0] code);
    return {pd, ch, code[CW-1:CW-4]};
  endfunction

  function automatic logic [7:0] rd_lo(input logic [CW-1:0] code);
    return {code[CW-5:0], 2'b00};
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_q <= scl_s[1];
      sda_q <= sda_s[1];
    end
  end

  assign sda_lvl   = sda_s[1];
  assign scl_rise  = ~scl_q & scl_s[1];
  assign scl_fall  = scl_q & ~scl_s[1];
  assign start_evt = scl_q & scl_s[1] & sda_q & ~sda_s[1];
  assign stop_evt  = scl_q & scl_s[1] & ~sda_q & sda_s[1];
endmodule

// File: rtl/qdac_bus.sv
module qdac_bus
  import qdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_lvl,
  input  logic [7:0] tx_hi,
  input  logic [7:0] tx_lo,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic       wr_first,
  output logic [7:0] wr_data,
  output logic       core_active,
  output logic       in_ack,
  output logic       in_tx,
  output logic       addr_eval,
  output logic       addr_hit
);
  bus_st_t    st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, wr_idx, rd_idx, mack;
  logic [7:0] nxt;

  assign nxt         = rd_idx ? tx_hi : tx_lo;
  assign core_active = (st != B_IDLE);
  assign in_ack      = (st == B_AACK) || (st == B_DACK);
  assign in_tx       = (st == B_TX);
  assign addr_hit    = addr_ok(sh, DEV_ADDR);
  assign addr_eval   = (st == B_ADDR) && scl_fall && (cnt == 4'd8) && !start_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= B_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      wr_idx   <= 1'b0;
      rd_idx   <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_first <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_evt) begin
        st     <= B_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        wr_idx <= 1'b0;
        rd_idx <= 1'b0;
      end else if (stop_evt) begin
        st     <= B_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          B_ADDR, B_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == B_RX) begin
                st     <= B_DACK;
                sda_oe <= 1'b1;
              end else if (addr_hit) begin
                st     <= B_AACK;
                sda_oe <= 1'b1;
                rw     <= sh[0];
              end else begin
                st <= B_IDLE;
              end
            end
          end
          B_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st     <= B_TX;
              sh     <= tx_hi;
              sda_oe <= ~tx_hi[7];
            end else begin
              st     <= B_RX;
              sda_oe <= 1'b0;
            end
          end
          B_DACK: if (scl_fall) begin
            st       <= B_RX;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            wr_valid <= 1'b1;
            wr_first <= ~wr_idx;
            wr_data  <= sh;
            wr_idx   <= ~wr_idx;
          end
          B_TX: begin
            if (scl_rise && cnt < 4'd8) cnt <= cnt + 4'd1;
            else if (scl_fall && cnt == 4'd8) begin
              st     <= B_RACK;
              sda_oe <= 1'b0;
            end else if (scl_fall && cnt != 4'd0) begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
          B_RACK: begin
            if (scl_rise) mack <= ~sda_lvl;
            else if (scl_fall) begin
              if (mack) begin
                st     <= B_TX;
                cnt    <= '0;
                sh     <= nxt;
                sda_oe <= ~nxt[7];
                rd_idx <= ~rd_idx;
              end else begin
                st <= B_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic               wr_first,
  input  logic [7:0]         wr_data,
  output logic [NCH*CW-1:0]  dac_code,
  output logic [NCH*PDW-1:0] pd_mode,
  output logic [7:0]         tx_hi,
  output logic [7:0]         tx_lo
);
  logic [7:0]     hold;
  logic [CHW-1:0] ptr;
  logic           commit;
  logic [3:0]     cmd;
  logic [CW-1:0]  new_code;

  assign commit   = wr_valid && !wr_first;
  assign cmd      = hold[7:4];
  assign new_code = code_of(hold, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      ptr  <= '0;
    end else begin
      if (wr_valid && wr_first) hold <= wr_data;
      if (commit && cmd < 4'(NCH)) ptr <= cmd[CHW-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dac_code[g*CW +: CW]   <= '0;
        pd_mode[g*PDW +: PDW]  <= '0;
      end else if (commit) begin
        if (cmd == 4'(g) || cmd == CMD_ALL)
          dac_code[g*CW +: CW] <= new_code;
        if (cmd == CMD_EXT && wr_data[4+g])
          pd_mode[g*PDW +: PDW] <= wr_data[PDW-1:0];
      end
    end
  end

  assign tx_hi = rd_hi(pd_mode[ptr*PDW +: PDW], ptr, dac_code[ptr*CW +: CW]);
  assign tx_lo = rd_lo(dac_code[ptr*CW +: CW]);
endmodule

// File: rtl/qdac_i2c_slave.sv
module qdac_i2c_slave
  import qdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [NCH*CW-1:0]  dac_code,
  output logic [NCH*PDW-1:0] pd_mode
);
  logic       sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_valid, wr_first, commit;
  logic [7:0] wr_data, tx_hi, tx_lo;
  logic       core_active, in_ack, in_tx, addr_eval, addr_hit;

  assign commit = wr_valid && !wr_first;

  qdac_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  qdac_bus #(.DEV_ADDR(DEV_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl),
    .tx_hi(tx_hi), .tx_lo(tx_lo), .sda_oe(sda_oe), .wr_valid(wr_valid),
    .wr_first(wr_first), .wr_data(wr_data), .core_active(core_active),
    .in_ack(in_ack), .in_tx(in_tx), .addr_eval(addr_eval), .addr_hit(addr_hit)
  );

  qdac_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_first(wr_first),
    .wr_data(wr_data), .dac_code(dac_code), .pd_mode(pd_mode),
    .tx_hi(tx_hi), .tx_lo(tx_lo)
  );
endmodule

// File: rtl/qdac_i2c_chk.sv
module qdac_i2c_chk
  import qdac_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sda_oe,
  input logic               core_active,
  input logic               in_ack,
  input logic               in_tx,
  input logic               start_evt,
  input logic               addr_eval,
  input logic               addr_hit,
  input logic               commit,
  input logic [NCH*CW-1:0]  dac_code,
  input logic [NCH*PDW-1:0] pd_mode
);
  AST_OE_ONLY_ACK_OR_TX: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (in_ack || in_tx)); // R2
  AST_MISS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_eval && !addr_hit) |=> (!sda_oe && !core_active)); // R3
  AST_GATED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_active && !start_evt) |=> (!sda_oe && !core_active)); // R4
  AST_START_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (core_active && !sda_oe)); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(dac_code)); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pd_mode)); // R7
endmodule

bind qdac_i2c_slave qdac_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .core_active(core_active),
  .in_ack(in_ack), .in_tx(in_tx), .start_evt(start_evt), .addr_eval(addr_eval),
  .addr_hit(addr_hit), .commit(commit), .dac_code(dac_code), .pd_mode(pd_mode)
);

// File: tb/tb_qdac_i2c_slave.sv
module tb_qdac_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WD = 190000;
  localparam logic [6:0] ADDR = 7'h3C;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [39:0] dac_code;
  logic [7:0]  pd_mode;
  int checks = 0, fails = 0;
  logic [9:0] ecode [4];
  logic [1:0] epd [4];
  int eptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  qdac_i2c_slave #(.DEV_ADDR(ADDR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .dac_code(dac_code), .pd_mode(pd_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) put_bit(b[7-i]);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0;
    end
    tick(2); sda_m = ~mack; tick(Q-2); scl_m = 1; tick(2*Q); scl_m = 0; tick(2); sda_m = 1; tick(Q-2);
  endtask

  function automatic void model_write(input logic [7:0] b0, input logic [7:0] b1);
    logic [3:0] c = b0[7:4];
    if (c < 4) begin ecode[c] = {b0[3:0], b1[7:2]}; eptr = int'(c); end
    else if (c == 4'h8) for (int n = 0; n < 4; n++) ecode[n] = {b0[3:0], b1[7:2]};
    else if (c == 4'hF) for (int n = 0; n < 4; n++) if (b1[4+n]) epd[n] = b1[1:0];
  endfunction

  function automatic logic [7:0] exp_hi();
    return {epd[eptr], 2'(eptr), ecode[eptr][9:6]};
  endfunction

  function automatic logic [7:0] exp_lo();
    return {ecode[eptr][5:0], 2'b00};
  endfunction

  task automatic check_regs(input string req);
    for (int n = 0; n < 4; n++) begin
      chk(req, 32'(dac_code[10*n +: 10]), 32'(ecode[n]));
      chk(req, 32'(pd_mode[2*n +: 2]), 32'(epd[n]));
    end
  endtask

  task automatic do_write(input logic [7:0] b0, input logic [7:0] b1, input string req);
    logic a0, a1, a2;
    i2c_start();
    send_byte({ADDR, 1'b0}, a0); send_byte(b0, a1); send_byte(b1, a2);
    i2c_stop(); tick(4);
    chk({req, " ack"}, 32'({a0, a1, a2}), 32'h7);
    model_write(b0, b1);
    check_regs(req);
  endtask

  task automatic do_read(input int nbytes, input string req);
    logic a; logic [7:0] r;
    i2c_start();
    send_byte({ADDR, 1'b1}, a);
    chk({req, " addr ack"}, 32'(a), 32'h1);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(r, k != nbytes - 1);
      chk(req, 32'(r), 32'((k % 2 == 0) ? exp_hi() : exp_lo()));
    end
    tick(4);
    chk("R11 released", 32'(sda_oe), 32'h0);
    i2c_stop(); tick(4);
  endtask

  task automatic bad_addr(input logic [7:0] ab, input string req);
    logic a0, a1, a2;
    i2c_start();
    send_byte(ab, a0); send_byte(8'h8F, a1); send_byte(8'hFF, a2);
    i2c_stop(); tick(4);
    chk(req, 32'({a0, a1, a2}), 32'h0);
    check_regs(req);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] r;
    void'($urandom(32'h5EED));
    for (int n = 0; n < 4; n++) begin ecode[n] = '0; epd[n] = '0; end
    tick(3);
    chk("R1 oe in reset", 32'(sda_oe), 32'h0);
    rst_n = 1; tick(5);
    check_regs("R1 reset");
    chk("R1 oe", 32'(sda_oe), 32'h0);

    do_write(8'h2A, 8'hB7, "R5 load ch2");
    do_write(8'h05, 8'h43, "R5 load ch0");
    do_write(8'h8C, 8'hFD, "R6 load all");
    do_write(8'hF3, 8'hA2, "R7 ext mask");
    do_write(8'hF0, 8'h51, "R7 ext mask2");
    do_write(8'h5F, 8'hFF, "R8 unused cmd");
    do_write(8'h3B, 8'h6C, "R5 load ch3");
    do_read(2, "R10 read");
    do_read(3, "R10 wrap");

    bad_addr(8'h00, "R3 general call");
    bad_addr(8'hF0, "R3 ten-bit hdr");
    bad_addr({7'h3D, 1'b0}, "R4 mismatch");

    i2c_start();
    send_byte({7'h11, 1'b0}, a0);
    send_byte(8'h1F, a1);
    i2c_start();
    send_byte({ADDR, 1'b0}, a2);
    chk("R4 gated then restart", 32'({a0, a1, a2}), 32'h1);
    send_byte(8'h1E, a0); send_byte(8'h88, a1);
    i2c_stop(); tick(4);
    model_write(8'h1E, 8'h88);
    check_regs("R4 restart write");

    i2c_start();
    send_byte({ADDR, 1'b0}, a0); send_byte(8'h0F, a1); send_bits(8'hFC, 4);
    i2c_stop(); tick(4);
    check_regs("R9 stop abort");
    i2c_start();
    send_byte({ADDR, 1'b0}, a0); send_byte(8'h8F, a1); send_bits(8'hFC, 5);
    i2c_start();
    i2c_stop(); tick(4);
    check_regs("R9 start abort");

    do_read(1, "R11 nack");
    send_byte(8'h00, a0);
    chk("R11 silent", 32'(a0), 32'h0);
    check_regs("R11 regs");

    for (int it = 0; it < 30; it++) begin
      logic [3:0] c;
      int k = int'($urandom % 7);
      case (k)
        0, 1, 2, 3: c = 4'(k);
        4: c = 4'h8;
        5: c = 4'hF;
        default: c = 4'(4 + ($urandom % 4));
      endcase
      do_write({c, 4'($urandom)}, 8'($urandom), "R5 random write");
      if (it % 5 == 4) do_read(2, "R10 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule